// File: doc/BRIEF.md
# Out-of-Band Flow-Control Receiver

This block terminates a three-wire out-of-band flow-control link: a forwarded clock, a serial data line and a frame-start marker sent by a remote transmitter. It samples the line on the forwarded clock and uses the marker to find frame boundaries. Each frame carries two segments, and each segment has its own 4-bit CRC. The block checks both CRCs and moves the checked results into a local system clock domain. That domain must run at no less than twice the forwarded clock rate.

On the system side, the application sees a calendar word, a per-lane status vector and one link status bit. For each of the two groups there is a one-cycle "new good value" pulse and a one-cycle "new value failed its CRC" pulse. A value that fails its CRC never reaches the outputs. The previous good value stays in place.

Top module: `oob_fc_rx`

## Requirements
- R1: After the asynchronous reset `arst` is released, `cal_out`, `lane_stat` and `link_stat` are all zero, and all four strobes are low until a segment has been received.
- R2: `fc_data` and `fc_sync` are sampled on the rising edge of `fc_clk`. The bit sampled with `fc_sync` high is bit 0 of a frame. A frame holds CAL_W calendar bits, most significant first. These are followed by 4 calendar CRC bits, then the lane bits from lane LANES-1 down to lane 0, then the link bit, then 4 status CRC bits.
- R3: Each segment CRC uses polynomial x^4+x+1. It is preset to 4'b1111 at the start of the segment and covers only that segment's data bits, fed most significant first. The received CRC is sent most significant bit first and must equal the computed value.
- R4: A calendar segment with a matching CRC loads `cal_out` and pulses `cal_upd` high for exactly one `sys_clk` cycle.
- R5: A calendar segment with a CRC mismatch pulses `cal_err` high for exactly one cycle and leaves `cal_out` unchanged.
- R6: A status segment with a matching CRC loads `lane_stat` and `link_stat` and pulses `stat_upd` high for exactly one cycle.
- R7: A status segment with a CRC mismatch pulses `stat_err` high for one cycle and leaves `lane_stat` and `link_stat` unchanged.
- R8: The update strobe and the error strobe of the same group are never high in the same cycle.
- R9: If `fc_sync` is seen before the current segment has finished, that segment produces no strobe. The bit sampled with `fc_sync` high then starts a new frame.
- R10: Bits sampled with `fc_sync` low while no frame is in progress are ignored. This covers bits before the first sync and bits after a frame has ended.
- R11: The two segments of one frame are judged independently. A bad calendar CRC does not affect a good status segment.
- R12: Frames sent back to back with no idle bits each produce exactly one strobe per segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fc_clk | input | 1 | Forwarded clock from the remote transmitter |
| fc_data | input | 1 | Serial flow-control data |
| fc_sync | input | 1 | High on the first bit of each frame |
| sys_clk | input | 1 | Local system clock, at least twice the rate of fc_clk |
| arst | input | 1 | Asynchronous reset, active high |
| cal_out | output | CAL_W | Last calendar word that passed its CRC |
| cal_upd | output | 1 | One-cycle pulse: new good calendar |
| cal_err | output | 1 | One-cycle pulse: calendar CRC failure |
| lane_stat | output | LANES | Last good per-lane status |
| link_stat | output | 1 | Last good link status |
| stat_upd | output | 1 | One-cycle pulse: new good status |
| stat_err | output | 1 | One-cycle pulse: status CRC failure |

## Verification
The embedded assertions check four things on every cycle. The strobes must be single-cycle and the strobes of a group mutually exclusive. An output value may change only together with its update strobe, and must hold still on an error. A sync must restart the bit position. Only the bench scenarios can show the rest. That includes whether bit order, segment layout and CRC arithmetic agree with a frame built independently. It also includes discarding a segment cut short by an early sync, ignoring unframed bits, judging the two segments separately, and handling frames sent back to back.

// File: rtl/oob_fc_pkg.sv
package oob_fc_pkg;

   localparam int          CRC_W      = 4;
   localparam logic [3:0]  CRC_PRESET = 4'b1111;
   // x^4 + x + 1 : feedback taps on bits 1 and 0
   localparam logic [3:0]  CRC_POLY   = 4'b0011;

   // one serial step of the segment CRC, most significant bit first
   function automatic logic [3:0] crc4_step(input logic [3:0] cur, input logic din);
      logic fb;
      fb = cur[3] ^ din;
      return {cur[2:0], 1'b0} ^ (fb ? CRC_POLY : 4'b0000);
   endfunction

endpackage

// File: rtl/oob_fc_rst_sync.sv
module oob_fc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("oob_fc_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain_q <= '1;
      else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
   end

   assign rst_out = chain_q[STAGES-1];

endmodule

// File: rtl/oob_fc_deframer.sv
module oob_fc_deframer
   import oob_fc_pkg::*;
#(
   parameter int CAL_W = 16,
   parameter int ST_W  = 5
) (
   input  logic             fc_clk,
   input  logic             rst_fc,
   input  logic             fc_data,
   input  logic             fc_sync,
   output logic [CAL_W-1:0] cal_hold,
   output logic             cal_good,
   output logic             cal_tog,
   output logic [ST_W-1:0]  st_hold,
   output logic             st_good,
   output logic             st_tog
);

   localparam int ST_BEG    = CAL_W + CRC_W;
   localparam int ST_CRC    = ST_BEG + ST_W;
   localparam int FRAME_LEN = ST_CRC + CRC_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);

   localparam logic [CNT_W-1:0] IDX_CAL_CRC = CNT_W'(CAL_W);
   localparam logic [CNT_W-1:0] IDX_ST_BEG  = CNT_W'(ST_BEG);
   localparam logic [CNT_W-1:0] IDX_ST_CRC  = CNT_W'(ST_CRC);
   localparam logic [CNT_W-1:0] IDX_CAL_END = CNT_W'(ST_BEG - 1);
   localparam logic [CNT_W-1:0] IDX_LAST    = CNT_W'(FRAME_LEN - 1);

   if (CAL_W < 2) begin : g_bad_cal
      $error("oob_fc_deframer: CAL_W must be at least 2");
   end
   if (ST_W < 2) begin : g_bad_st
      $error("oob_fc_deframer: ST_W must be at least 2");
   end

   logic             in_frame;
   logic [CNT_W-1:0] bit_cnt;
   logic [CAL_W-1:0] cal_sh;
   logic [ST_W-1:0]  st_sh;
   logic [3:0]       crc_calc;
   logic [3:0]       crc_rx;

   logic             active;
   logic [CNT_W-1:0] idx;
   logic [3:0]       crc_base;
   logic [3:0]       crc_rx_nxt;
   logic             ph_cal, ph_cal_crc, ph_st;
   logic             end_cal, end_st;

   always_comb begin
      active     = fc_sync | in_frame;
      idx        = fc_sync ? '0 : bit_cnt;
      crc_base   = fc_sync ? CRC_PRESET : crc_calc;
      crc_rx_nxt = {crc_rx[2:0], fc_data};
      ph_cal     = idx < IDX_CAL_CRC;
      ph_cal_crc = (idx >= IDX_CAL_CRC) && (idx < IDX_ST_BEG);
      ph_st      = (idx >= IDX_ST_BEG) && (idx < IDX_ST_CRC);
      end_cal    = idx == IDX_CAL_END;
      end_st     = idx == IDX_LAST;
   end

   always_ff @(posedge fc_clk or posedge rst_fc) begin
      if (rst_fc) begin
         in_frame <= 1'b0;
         bit_cnt  <= '0;
         cal_sh   <= '0;
         st_sh    <= '0;
         crc_calc <= CRC_PRESET;
         crc_rx   <= '0;
         cal_hold <= '0;
         cal_good <= 1'b0;
         cal_tog  <= 1'b0;
         st_hold  <= '0;
         st_good  <= 1'b0;
         st_tog   <= 1'b0;
      end else if (active) begin
         in_frame <= !end_st;
         bit_cnt  <= idx + 1'b1;
         if (ph_cal) begin
            cal_sh   <= {cal_sh[CAL_W-2:0], fc_data};
            crc_calc <= crc4_step(crc_base, fc_data);
         end else if (ph_cal_crc) begin
            crc_rx <= crc_rx_nxt;
            if (end_cal) begin
               cal_hold <= cal_sh;
               cal_good <= (crc_rx_nxt == crc_calc);
               cal_tog  <= ~cal_tog;
               crc_calc <= CRC_PRESET;
            end
         end else if (ph_st) begin
            st_sh    <= {st_sh[ST_W-2:0], fc_data};
            crc_calc <= crc4_step(crc_base, fc_data);
         end else begin
            crc_rx <= crc_rx_nxt;
            if (end_st) begin
               st_hold <= st_sh;
               st_good <= (crc_rx_nxt == crc_calc);
               st_tog  <= ~st_tog;
            end
         end
      end
   end

   // R9
   sync_restart_chk: assert property (@(posedge fc_clk) disable iff (rst_fc)
      fc_sync |=> (bit_cnt == CNT_W'(1)));

   // R2
   seg_order_chk: assert property (@(posedge fc_clk) disable iff (rst_fc)
      !((cal_tog != $past(cal_tog)) && (st_tog != $past(st_tog))));

endmodule

// File: rtl/oob_fc_seg_cdc.sv
module oob_fc_seg_cdc #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         sys_clk,
   input  logic         rst_sys,
   input  logic [W-1:0] seg_data,
   input  logic         seg_good,
   input  logic         seg_tog,
   output logic [W-1:0] val,
   output logic         upd,
   output logic         err
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("oob_fc_seg_cdc: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q;
   logic                   flip;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge sys_clk or posedge rst_sys) begin
            if (rst_sys) sync_q[0] <= 1'b0;
            else         sync_q[0] <= seg_tog;
         end
      end else begin : g_next
         always_ff @(posedge sys_clk or posedge rst_sys) begin
            if (rst_sys) sync_q[i] <= 1'b0;
            else         sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign flip = sync_q[SYNC_STAGES-1] ^ seen_q;

   always_ff @(posedge sys_clk or posedge rst_sys) begin
      if (rst_sys) begin
         seen_q <= 1'b0;
         val    <= '0;
         upd    <= 1'b0;
         err    <= 1'b0;
      end else begin
         seen_q <= sync_q[SYNC_STAGES-1];
         upd    <= flip & seg_good;
         err    <= flip & ~seg_good;
         if (flip && seg_good) val <= seg_data;
      end
   end

   // R8
   upd_err_excl_chk: assert property (@(posedge sys_clk) disable iff (rst_sys)
      !(upd && err));

   // R4
   upd_single_chk: assert property (@(posedge sys_clk) disable iff (rst_sys)
      upd |=> !upd);

   // R5
   hold_on_err_chk: assert property (@(posedge sys_clk) disable iff (rst_sys)
      err |-> $stable(val));

   // R6
   change_with_upd_chk: assert property (@(posedge sys_clk) disable iff (rst_sys)
      !$stable(val) |-> upd);

endmodule

// File: rtl/oob_fc_rx.sv
module oob_fc_rx
   import oob_fc_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int CAL_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             fc_clk,
   input  logic             fc_data,
   input  logic             fc_sync,
   input  logic             sys_clk,
   input  logic             arst,
   output logic [CAL_W-1:0] cal_out,
   output logic             cal_upd,
   output logic             cal_err,
   output logic [LANES-1:0] lane_stat,
   output logic             link_stat,
   output logic             stat_upd,
   output logic             stat_err
);

   localparam int ST_W = LANES + 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("oob_fc_rx: LANES must be at least 1");
   end

   logic             rst_fc, rst_sys;
   logic [CAL_W-1:0] cal_hold;
   logic             cal_good, cal_tog;
   logic [ST_W-1:0]  st_hold;
   logic             st_good, st_tog;
   logic [ST_W-1:0]  st_val;

   oob_fc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_fc (
      .clk(fc_clk), .arst(arst), .rst_out(rst_fc));

   oob_fc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
      .clk(sys_clk), .arst(arst), .rst_out(rst_sys));

   oob_fc_deframer #(.CAL_W(CAL_W), .ST_W(ST_W)) u_deframer (
      .fc_clk   (fc_clk),
      .rst_fc   (rst_fc),
      .fc_data  (fc_data),
      .fc_sync  (fc_sync),
      .cal_hold (cal_hold),
      .cal_good (cal_good),
      .cal_tog  (cal_tog),
      .st_hold  (st_hold),
      .st_good  (st_good),
      .st_tog   (st_tog)
   );

   oob_fc_seg_cdc #(.W(CAL_W), .SYNC_STAGES(SYNC_STAGES)) u_cal_cdc (
      .sys_clk  (sys_clk),
      .rst_sys  (rst_sys),
      .seg_data (cal_hold),
      .seg_good (cal_good),
      .seg_tog  (cal_tog),
      .val      (cal_out),
      .upd      (cal_upd),
      .err      (cal_err)
   );

   oob_fc_seg_cdc #(.W(ST_W), .SYNC_STAGES(SYNC_STAGES)) u_st_cdc (
      .sys_clk  (sys_clk),
      .rst_sys  (rst_sys),
      .seg_data (st_hold),
      .seg_good (st_good),
      .seg_tog  (st_tog),
      .val      (st_val),
      .upd      (stat_upd),
      .err      (stat_err)
   );

   assign lane_stat = st_val[ST_W-1:1];
   assign link_stat = st_val[0];

endmodule

// File: tb/sim_oob_fc_rx.sv
module sim_oob_fc_rx;

   localparam int LANES = 4;
   localparam int CAL_W = 16;

   logic             fc_clk = 1'b0, sys_clk = 1'b0;
   logic             arst = 1'b1, fc_data = 1'b0, fc_sync = 1'b0;
   logic [CAL_W-1:0] cal_out;
   logic             cal_upd, cal_err, link_stat, stat_upd, stat_err;
   logic [LANES-1:0] lane_stat;

   oob_fc_rx #(.LANES(LANES), .CAL_W(CAL_W), .SYNC_STAGES(2)) u0 (
      .fc_clk(fc_clk), .fc_data(fc_data), .fc_sync(fc_sync),
      .sys_clk(sys_clk), .arst(arst),
      .cal_out(cal_out), .cal_upd(cal_upd), .cal_err(cal_err),
      .lane_stat(lane_stat), .link_stat(link_stat),
      .stat_upd(stat_upd), .stat_err(stat_err));

   always #10 sys_clk = ~sys_clk;   // 50 MHz
   always #25 fc_clk  = ~fc_clk;    // 20 MHz forwarded clock

   int checks = 0, fails = 0;
   int n_cu = 0, n_ce = 0, n_su = 0, n_se = 0, n_both = 0, n_long = 0;
   logic prev_cu = 1'b0, prev_su = 1'b0;
   bit done = 1'b0;

   always @(negedge sys_clk) begin
      if (!arst) begin
         if (cal_upd)  n_cu++;
         if (cal_err)  n_ce++;
         if (stat_upd) n_su++;
         if (stat_err) n_se++;
         if ((cal_upd && cal_err) || (stat_upd && stat_err)) n_both++;
         if ((cal_upd && prev_cu) || (stat_upd && prev_su)) n_long++;
         prev_cu = cal_upd;
         prev_su = stat_upd;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_crc(input logic [31:0] v, input int n);
      logic [3:0] c;
      logic       fb;
      c = 4'b1111;
      for (int i = n - 1; i >= 0; i--) begin
         fb = c[3] ^ v[i];
         c  = {c[2:0], 1'b0};
         if (fb) c = c ^ 4'b0011;
      end
      return c;
   endfunction

   task automatic send_bit(input logic s, input logic d);
      @(negedge fc_clk);
      fc_sync = s;
      fc_data = d;
   endtask

   // cut < 0 sends the whole frame, otherwise only the first cut bits
   task automatic send_frame(input logic [15:0] cal, input logic [3:0] lanes,
                             input logic link, input logic bad_cal,
                             input logic bad_st, input int cut);
      logic       fb[64];
      logic [3:0] cc, sc;
      logic [4:0] sv;
      int         k, lim;
      k  = 0;
      cc = ref_crc({16'h0, cal}, 16) ^ {bad_cal, 3'b000};
      sv = {lanes, link};
      sc = ref_crc({27'h0, sv}, 5) ^ {3'b000, bad_st};
      for (int i = 15; i >= 0; i--) begin fb[k] = cal[i]; k++; end
      for (int i = 3; i >= 0; i--)  begin fb[k] = cc[i];  k++; end
      for (int i = 4; i >= 0; i--)  begin fb[k] = sv[i];  k++; end
      for (int i = 3; i >= 0; i--)  begin fb[k] = sc[i];  k++; end
      lim = (cut < 0) ? k : cut;
      for (int j = 0; j < lim; j++) send_bit(j == 0, fb[j]);
   endtask

   task automatic settle();
      send_bit(1'b0, 1'b0);
      repeat (14) @(negedge sys_clk);
   endtask

   task automatic clear_counts();
      n_cu = 0; n_ce = 0; n_su = 0; n_se = 0; n_both = 0; n_long = 0;
   endtask

   task automatic t_reset();
      chk("R1 cal_out",   32'(cal_out),   32'h0);
      chk("R1 lane_stat", 32'(lane_stat), 32'h0);
      chk("R1 link_stat", 32'(link_stat), 32'h0);
      chk("R1 strobes",   32'(n_cu + n_ce + n_su + n_se), 32'h0);
   endtask

   task automatic t_good_frame();
      clear_counts();
      send_frame(16'hA5C3, 4'b1010, 1'b1, 1'b0, 1'b0, -1);
      settle();
      chk("R4 cal_upd count", 32'(n_cu), 32'd1);
      chk("R2 R3 cal_out",    32'(cal_out), 32'hA5C3);
      chk("R6 stat_upd count", 32'(n_su), 32'd1);
      chk("R2 lane_stat",     32'(lane_stat), 32'hA);
      chk("R6 link_stat",     32'(link_stat), 32'h1);
      chk("R3 no errors",     32'(n_ce + n_se), 32'h0);
      chk("R4 single cycle",  32'(n_long), 32'h0);
   endtask

   task automatic t_bad_cal();
      clear_counts();
      send_frame(16'h1234, 4'b0101, 1'b0, 1'b1, 1'b0, -1);
      settle();
      chk("R5 cal_err count", 32'(n_ce), 32'd1);
      chk("R5 cal_out held",  32'(cal_out), 32'hA5C3);
      chk("R5 no cal_upd",    32'(n_cu), 32'd0);
      chk("R11 stat_upd",     32'(n_su), 32'd1);
      chk("R11 lane_stat",    32'(lane_stat), 32'h5);
      chk("R11 link_stat",    32'(link_stat), 32'h0);
   endtask

   task automatic t_bad_status();
      clear_counts();
      send_frame(16'h0F0F, 4'b1111, 1'b1, 1'b0, 1'b1, -1);
      settle();
      chk("R7 stat_err count", 32'(n_se), 32'd1);
      chk("R7 lane_stat held", 32'(lane_stat), 32'h5);
      chk("R7 link_stat held", 32'(link_stat), 32'h0);
      chk("R7 cal still good", 32'(cal_out), 32'h0F0F);
      chk("R8 no overlap",     32'(n_both), 32'h0);
   endtask

   task automatic t_truncated();
      clear_counts();
      send_frame(16'h1111, 4'b1001, 1'b1, 1'b0, 1'b0, 8);
      send_frame(16'h2222, 4'b0110, 1'b0, 1'b0, 1'b0, -1);
      settle();
      chk("R9 cut calendar cal_upd", 32'(n_cu), 32'd1);
      chk("R9 cut calendar cal_out", 32'(cal_out), 32'h2222);
      chk("R9 cut calendar errors",  32'(n_ce + n_se), 32'd0);
      chk("R9 lane_stat",            32'(lane_stat), 32'h6);
      clear_counts();
      send_frame(16'h3333, 4'b1111, 1'b1, 1'b0, 1'b0, 22);
      send_frame(16'h4444, 4'b0001, 1'b0, 1'b0, 1'b0, -1);
      settle();
      chk("R9 cut status cal_upd",  32'(n_cu), 32'd2);
      chk("R9 cut status stat_upd", 32'(n_su), 32'd1);
      chk("R9 cut status lanes",    32'(lane_stat), 32'h1);
      chk("R9 cut status errors",   32'(n_ce + n_se), 32'd0);
   endtask

   task automatic t_unframed();
      clear_counts();
      for (int i = 0; i < 40; i++) send_bit(1'b0, (i % 3) != 0);
      settle();
      chk("R10 no strobes", 32'(n_cu + n_ce + n_su + n_se), 32'd0);
      chk("R10 cal_out",    32'(cal_out), 32'h4444);
      chk("R10 lane_stat",  32'(lane_stat), 32'h1);
   endtask

   task automatic t_back_to_back();
      clear_counts();
      send_frame(16'h0001, 4'b1111, 1'b0, 1'b0, 1'b0, -1);
      send_frame(16'h8000, 4'b0000, 1'b0, 1'b0, 1'b0, -1);
      send_frame(16'hFFFF, 4'b1001, 1'b1, 1'b0, 1'b0, -1);
      settle();
      chk("R12 cal_upd count",  32'(n_cu), 32'd3);
      chk("R12 stat_upd count", 32'(n_su), 32'd3);
      chk("R12 cal_out",        32'(cal_out), 32'hFFFF);
      chk("R12 lane_stat",      32'(lane_stat), 32'h9);
      chk("R12 link_stat",      32'(link_stat), 32'h1);
      chk("R8 no overlap",      32'(n_both), 32'h0);
   endtask

   initial begin
      repeat (5) @(negedge sys_clk);
      for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b1);
      arst = 1'b0;
      repeat (10) @(negedge sys_clk);
      t_reset();
      t_good_frame();
      t_bad_cal();
      t_bad_status();
      t_truncated();
      t_unframed();
      t_back_to_back();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(negedge sys_clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule